// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block splits the oscillator clock into instruction cycles of four phases and drives one phase per clock. The phases are decode, operand read, process and write-back, in that order. For each phase the block gives a one-hot phase vector and a gated enable. It also gives a one-clock instruction-cycle strobe in the last phase, which a cycle counter can use.

The block also turns two-cycle instructions into their second, empty cycle. The execute stage raises `skip_taken_i` when a conditional test skips the next instruction. It raises `branch_i` when the program counter is loaded, as for call, goto and every kind of return. Either request is sampled at the clock edge that ends the write-back phase. If it is present there, the whole next instruction cycle runs as a forced no-operation. During that cycle `squash_o` is high and all four enables stay low.

A squashed cycle executes nothing, so it cannot issue a request of its own. A request seen at the end of a squashed cycle is dropped. One request therefore never costs more than one cycle.

All pins are plain control signals. No stream interface exists, so back-pressure does not apply.

Top module: `quad_phase_seq`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `phase_o` is 4'b0001 (decode), `squash_o` is 0 and `cyc_strobe_o` is 0.
- R2: Exactly one bit of `phase_o` is set in every clock. Bit 0 is decode, bit 1 is read, bit 2 is process and bit 3 is write-back. The set bit moves to the next phase on every rising clock edge, and after bit 3 comes bit 0.
- R3: `cyc_strobe_o` is high exactly in the clocks where `phase_o[3]` is set. It therefore pulses once every four clocks, whether the cycle is squashed or not.
- R4: In a cycle that is not squashed, `decode_en_o`, `read_en_o`, `process_en_o` and `write_en_o` are each high only in their own phase (bits 0, 1, 2 and 3 of `phase_o`).
- R5: If `skip_taken_i` or `branch_i` (or both) is high at the rising edge that ends write-back of a cycle that is not squashed, the next instruction cycle is squashed, and `squash_o` is high for all four of its clocks.
- R6: During a squashed cycle all four enables are low.
- R7: `skip_taken_i` and `branch_i` have no effect when they are sampled at the edges that end decode, read or process.
- R8: A request at the edge that ends a squashed cycle is ignored, and the next cycle executes. If the requests are held high all the time, squashed cycles and executed cycles alternate.
- R9: `squash_o` changes value only in a clock where `phase_o` becomes 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| skip_taken_i | input | 1 | Execute stage reports a taken conditional skip |
| branch_i | input | 1 | Execute stage reports a program-counter load |
| phase_o | output | 4 | One-hot current phase, bit 0 = decode … bit 3 = write-back |
| decode_en_o | output | 1 | Decode enable, low when squashed |
| read_en_o | output | 1 | Operand read enable, low when squashed |
| process_en_o | output | 1 | Process enable, low when squashed |
| write_en_o | output | 1 | Write-back enable, low when squashed |
| cyc_strobe_o | output | 1 | One-clock strobe in the write-back phase of every cycle |
| squash_o | output | 1 | High for the whole of a forced no-operation cycle |

## Verification
A phase ring that has lost its single token shows up at once, in the same clock. Either several enables rise together or none do, and the strobe spacing breaks within four clocks. A wrong squash state shows up no later than the next decode phase, because the enables of a whole cycle either appear or vanish. A stuck squash flag shows up after at most two cycles when requests are held high, because the strict alternation of executed and empty cycles no longer holds. Each of these faults is caught by comparing every output, on every clock, against an independent model of phase and squash.

// File: rtl/qps_pkg.sv
package qps_pkg;
  // Number of phases in one instruction cycle.
  localparam int unsigned QPS_PHASES = 4;
  localparam int unsigned QPS_PW     = $clog2(QPS_PHASES);

  // Phase indices into the one-hot vector.
  typedef enum logic [QPS_PW-1:0] {
    PH_DECODE  = 2'd0,
    PH_READ    = 2'd1,
    PH_PROCESS = 2'd2,
    PH_WRITE   = 2'd3
  } qps_phase_e;
endpackage

// File: rtl/qps_phase_ring.sv
// One-hot ring: one token walks through NUM_PHASES positions, one per clock.
module qps_phase_ring #(
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  first_o,
  output logic                  last_o
);
  localparam int unsigned LAST = NUM_PHASES - 1;
  localparam logic [NUM_PHASES-1:0] START = {{(NUM_PHASES-1){1'b0}}, 1'b1};

  logic [NUM_PHASES-1:0] ring_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= START;
    else        ring_q <= {ring_q[LAST-1:0], ring_q[LAST]};
  end

  assign phase_o = ring_q;
  assign first_o = ring_q[0];
  assign last_o  = ring_q[LAST];
endmodule

// File: rtl/qps_squash_ctl.sv
// Samples skip/branch at the end of the last phase; a squashed cycle
// cannot request another squash.
module qps_squash_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_end_i,
  input  logic skip_i,
  input  logic branch_i,
  output logic squash_o
);
  logic squash_q;
  logic request;

  assign request = skip_i | branch_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           squash_q <= 1'b0;
    else if (cycle_end_i) squash_q <= request & ~squash_q;
  end

  assign squash_o = squash_q;
endmodule

// File: rtl/qps_enable_gate.sv
// Per-phase enables, blocked for the whole of a squashed cycle.
module qps_enable_gate #(
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic [NUM_PHASES-1:0] phase_i,
  input  logic                  squash_i,
  output logic [NUM_PHASES-1:0] en_o
);
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_en
    assign en_o[g] = phase_i[g] & ~squash_i;
  end
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import qps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  skip_taken_i,
  input  logic                  branch_i,
  output logic [QPS_PHASES-1:0] phase_o,
  output logic                  decode_en_o,
  output logic                  read_en_o,
  output logic                  process_en_o,
  output logic                  write_en_o,
  output logic                  cyc_strobe_o,
  output logic                  squash_o
);
  logic [QPS_PHASES-1:0] phase;
  logic [QPS_PHASES-1:0] en;
  logic                  first_ph;
  logic                  last_ph;
  logic                  squash;

  qps_phase_ring #(.NUM_PHASES(QPS_PHASES)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase),
    .first_o (first_ph),
    .last_o  (last_ph)
  );

  qps_squash_ctl u_squash (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_end_i (last_ph),
    .skip_i      (skip_taken_i),
    .branch_i    (branch_i),
    .squash_o    (squash)
  );

  qps_enable_gate #(.NUM_PHASES(QPS_PHASES)) u_gate (
    .phase_i  (phase),
    .squash_i (squash),
    .en_o     (en)
  );

  logic unused_first;
  assign unused_first = first_ph;

  assign phase_o      = phase;
  assign decode_en_o  = en[PH_DECODE];
  assign read_en_o    = en[PH_READ];
  assign process_en_o = en[PH_PROCESS];
  assign write_en_o   = en[PH_WRITE];
  assign cyc_strobe_o = last_ph;
  assign squash_o     = squash;
endmodule

// File: rtl/qps_seq_checker.sv
module qps_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       skip_taken_i,
  input logic       branch_i,
  input logic [3:0] phase_o,
  input logic       decode_en_o,
  input logic       read_en_o,
  input logic       process_en_o,
  input logic       write_en_o,
  input logic       cyc_strobe_o,
  input logic       squash_o
);
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1);

  a_r2_advance_q1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[0] |=> phase_o[1]);

  a_r2_wrap_q4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[3] |=> phase_o[0]);

  a_r3_strobe_q4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe_o == phase_o[3]);

  a_r6_quiet_squash: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> !(decode_en_o || read_en_o || process_en_o || write_en_o));

  a_r4_live_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !squash_o |-> {write_en_o, process_en_o, read_en_o, decode_en_o} == phase_o);

  a_r5_request_squash: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[3] && !squash_o && (skip_taken_i || branch_i) |=> squash_o);

  a_r5_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[3] && !skip_taken_i && !branch_i |=> !squash_o);

  a_r8_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[3] && squash_o |=> !squash_o);

  a_r9_change_at_q1: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o[3] |=> $stable(squash_o));
endmodule

bind quad_phase_seq qps_seq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .skip_taken_i (skip_taken_i),
  .branch_i     (branch_i),
  .phase_o      (phase_o),
  .decode_en_o  (decode_en_o),
  .read_en_o    (read_en_o),
  .process_en_o (process_en_o),
  .write_en_o   (write_en_o),
  .cyc_strobe_o (cyc_strobe_o),
  .squash_o     (squash_o)
);

// File: tb/quad_phase_seq_tb.sv
`timescale 1ns/1ps
module quad_phase_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       skip_taken_i = 1'b0;
  logic       branch_i = 1'b0;
  logic [3:0] phase_o;
  logic       decode_en_o, read_en_o, process_en_o, write_en_o;
  logic       cyc_strobe_o, squash_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  quad_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .skip_taken_i(skip_taken_i), .branch_i(branch_i),
    .phase_o(phase_o), .decode_en_o(decode_en_o), .read_en_o(read_en_o),
    .process_en_o(process_en_o), .write_en_o(write_en_o),
    .cyc_strobe_o(cyc_strobe_o), .squash_o(squash_o)
  );

  // Behavioural reference: a phase number and a squash bit.
  int m_ph = 0;
  bit m_sq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_sq = 0;
    end else begin
      if (m_ph == 3) m_sq = (skip_taken_i || branch_i) && !m_sq;
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison, away from the active edge.
  bit run_cmp = 0;
  int sq_cycles = 0;
  int prev_sq_cycle = 0;
  int double_sq = 0;
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R2 phase", phase_o, 4'b0001 << m_ph);
      chk("R3 strobe", cyc_strobe_o, m_ph == 3);
      chk("R5 R8 R9 squash", squash_o, m_sq);
      if (m_sq) chk("R6 enables", {write_en_o, process_en_o, read_en_o, decode_en_o}, 0);
      else      chk("R4 enables", {write_en_o, process_en_o, read_en_o, decode_en_o}, 4'b0001 << m_ph);
      if (m_ph == 0) begin
        if (squash_o) sq_cycles++;
        if (squash_o && prev_sq_cycle == 1) double_sq++;
        prev_sq_cycle = squash_o ? 1 : 0;
      end
    end
  end

  task automatic to_phase(input int p);
    do @(negedge clk); while (m_ph != p);
  endtask

  task automatic req_at_q4(input bit s, input bit b);
    to_phase(3);
    skip_taken_i = s; branch_i = b;
    @(negedge clk);
    skip_taken_i = 0; branch_i = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", phase_o, 4'b0001);
    chk("R1 squash in reset", squash_o, 0);
    chk("R1 strobe in reset", cyc_strobe_o, 0);
    rst_n = 1'b1;
    chk("R1 phase after release", phase_o, 4'b0001);
    run_cmp = 1;

    repeat (16) @(negedge clk);        // free run, R2 R3 R4

    req_at_q4(1, 0);                    // skip, R5
    repeat (8) @(negedge clk);
    req_at_q4(0, 1);                    // branch, R5
    repeat (8) @(negedge clk);
    req_at_q4(1, 1);                    // both
    repeat (8) @(negedge clk);

    // R7: requests only in decode/read/process
    sq_cycles = 0;
    for (int i = 0; i < 4; i++) begin
      to_phase(0);
      skip_taken_i = 1; branch_i = (i % 2);
      to_phase(3);
      skip_taken_i = 0; branch_i = 0;
    end
    repeat (8) @(negedge clk);
    chk("R7 requests outside write-back ignored", sq_cycles, 0);

    // R8: requests held high -> strict alternation
    sq_cycles = 0; double_sq = 0;
    to_phase(0);
    skip_taken_i = 1;
    repeat (32) @(negedge clk);
    skip_taken_i = 0;
    repeat (8) @(negedge clk);
    chk("R8 no back-to-back squash", double_sq, 0);
    chk("R8 squashed cycle count", sq_cycles, 4);

    // Request at end of a squashed cycle dropped (R8)
    req_at_q4(0, 1);
    to_phase(3);
    branch_i = 1;
    @(negedge clk);
    branch_i = 0;
    chk("R8 squash cleared after dropped request", squash_o, 0);
    repeat (8) @(negedge clk);

    // Reset mid-run returns to start (R1)
    to_phase(2);
    rst_n = 0;
    @(negedge clk);
    chk("R1 phase after mid-run reset", phase_o, 4'b0001);
    rst_n = 1;
    repeat (8) @(negedge clk);

    run_cmp = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule